// File: doc/BRIEF.md
# Prefetched-Line State Tracker with Metrics

This block follows the prefetch life of a small set of tracked cache lines, one status per line. A line is idle (no prefetch activity), waiting for prefetch data, or filled by a prefetch and not yet touched by a demand access. The surrounding cache controller reports five kinds of local event, each on its own valid/index port: a shared (read) demand access, an exclusive demand access, a replacement, the issue of a prefetch, and the arrival of prefetch data.

Each event changes the state of the line it names. In the same step the block keeps four saturating counters: prefetches accepted, prefetch hits, prefetched lines evicted without use, and demand shared reads that would have missed without prefetching. Accuracy is hits divided by accepted prefetches. Coverage is hits divided by would-miss demand reads.

The first shared read to a prefetched line counts as a hit. It also raises a one-cycle train pulse carrying the line index, so that the stride detector is updated as if that read had missed. After the hit the line leaves the tracked states. All outputs are registered and appear one clock after the event.

Top module: `pft_line_tracker`

## Requirements
- R1: Synchronous active-low reset clears all four counters, deasserts the train pulse and returns every line to the idle state.
- R2: A prefetch issue to an idle line moves it to waiting and adds one to the issued counter. A prefetch issue to a waiting or filled line is ignored and not counted.
- R3: A data acknowledgement moves a waiting line to filled. An acknowledgement to an idle or filled line is ignored.
- R4: A shared read to a filled line adds one to the hit counter and one to the demand counter, pulses train_vld with train_idx equal to the read index, and returns the line to idle.
- R5: A shared read to a waiting line adds one to the demand counter and leaves the line waiting. A shared read to an idle line adds one to the demand counter only when rd_miss is 1.
- R6: A replacement of a filled line adds one to the unused-eviction counter and returns it to idle. A replacement of a waiting line returns it to idle without counting.
- R7: An exclusive access to a waiting or filled line returns it to idle. It changes no counter and raises no train pulse.
- R8: When several events name the same line in one cycle, only the highest-ranked one takes effect. The ranking from high to low is exclusive, replacement, shared read, acknowledgement, issue. The others are dropped without counting.
- R9: Events that name different lines in the same cycle all take effect together.
- R10: Each counter (CNT_W bits, default 32) holds at all ones instead of wrapping.
- R11: Counter updates and the train pulse appear on the outputs exactly one clock after the event is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_vld | input | 1 | Shared demand read event |
| rd_idx | input | IDX_W | Line index of the shared read |
| rd_miss | input | 1 | The shared read missed the cache |
| ex_vld | input | 1 | Exclusive demand access event |
| ex_idx | input | IDX_W | Line index of the exclusive access |
| rp_vld | input | 1 | Replacement event |
| rp_idx | input | IDX_W | Line index being replaced |
| pi_vld | input | 1 | Prefetch issue event |
| pi_idx | input | IDX_W | Line index being prefetched |
| pa_vld | input | 1 | Prefetch data acknowledgement |
| pa_idx | input | IDX_W | Line index whose prefetch data arrived |
| train_vld | output | 1 | Pulse: prefetched line used, train the prefetcher |
| train_idx | output | IDX_W | Line index carried by the train pulse |
| cnt_issued | output | CNT_W | Accepted prefetch issues |
| cnt_hit | output | CNT_W | Prefetch hits |
| cnt_demand | output | CNT_W | Shared reads that would have missed |
| cnt_unused | output | CNT_W | Filled lines evicted without use |

## Verification
Two functions often land in the same cycle. One is the per-line state change from a demand access. The other is a prefetch handshake or eviction on either the same line or a different one. The bench provokes this with directed cycles that put a read and an exclusive access on one filled line, and a replacement and an issue on one idle line. It also runs a random stream over only four lines with every event port active at high rates, so that same-line and cross-line collisions are frequent. The bench model applies the ranking rule on its own, and each cycle it compares every counter and the train pulse with that model.

// File: rtl/pft_line_pkg.sv
package pft_line_pkg;

    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_WAIT = 2'd1,
        LN_FILL = 2'd2
    } line_st_e;

    localparam int NUM_CNT = 4;
    localparam int CNT_ISSUED = 0;
    localparam int CNT_HIT    = 1;
    localparam int CNT_DEMAND = 2;
    localparam int CNT_UNUSED = 3;

    typedef struct packed {
        logic rd;
        logic ex;
        logic rp;
        logic pi;
        logic pa;
    } line_evt_t;

    typedef struct packed {
        logic issued;
        logic hit;
        logic demand;
        logic unused;
    } line_flag_t;

endpackage

// File: rtl/pft_line_cell.sv
module pft_line_cell
    import pft_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  line_evt_t  evt,
    input  logic       rd_miss,
    output line_flag_t flag
);

    typedef struct packed {
        line_st_e st;
    } cell_state_t;

    cell_state_t s_d, s_q;
    line_flag_t  flag_d;

    always_comb begin
        s_d    = s_q;
        flag_d = '0;
        if (evt.ex) begin
            s_d.st = LN_IDLE;
        end else if (evt.rp) begin
            if (s_q.st == LN_FILL) flag_d.unused = 1'b1;
            s_d.st = LN_IDLE;
        end else if (evt.rd) begin
            unique case (s_q.st)
                LN_FILL: begin
                    flag_d.hit    = 1'b1;
                    flag_d.demand = 1'b1;
                    s_d.st        = LN_IDLE;
                end
                LN_WAIT: flag_d.demand = 1'b1;
                default: flag_d.demand = rd_miss;
            endcase
        end else if (evt.pa) begin
            if (s_q.st == LN_WAIT) s_d.st = LN_FILL;
        end else if (evt.pi) begin
            if (s_q.st == LN_IDLE) begin
                s_d.st        = LN_WAIT;
                flag_d.issued = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: LN_IDLE};
        else        s_q <= s_d;
    end

    assign flag = flag_d;

endmodule

// File: rtl/pft_sat_cnt.sv
module pft_sat_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != {CNT_W{1'b1}})) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/pft_line_tracker.sv
module pft_line_tracker
    import pft_line_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int CNT_W     = 32,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_vld,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_miss,
    input  logic             ex_vld,
    input  logic [IDX_W-1:0] ex_idx,
    input  logic             rp_vld,
    input  logic [IDX_W-1:0] rp_idx,
    input  logic             pi_vld,
    input  logic [IDX_W-1:0] pi_idx,
    input  logic             pa_vld,
    input  logic [IDX_W-1:0] pa_idx,
    output logic             train_vld,
    output logic [IDX_W-1:0] train_idx,
    output logic [CNT_W-1:0] cnt_issued,
    output logic [CNT_W-1:0] cnt_hit,
    output logic [CNT_W-1:0] cnt_demand,
    output logic [CNT_W-1:0] cnt_unused
);

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } train_t;

    line_flag_t             flags [NUM_LINES];
    logic [NUM_LINES-1:0]   hit_vec, iss_vec, dem_vec, unu_vec;
    logic [NUM_CNT-1:0]     inc;
    logic [CNT_W-1:0]       cnt_arr [NUM_CNT];
    train_t                 tr_d, tr_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_evt_t ev;
        always_comb begin
            ev.rd = rd_vld && (rd_idx == IDX_W'(g));
            ev.ex = ex_vld && (ex_idx == IDX_W'(g));
            ev.rp = rp_vld && (rp_idx == IDX_W'(g));
            ev.pi = pi_vld && (pi_idx == IDX_W'(g));
            ev.pa = pa_vld && (pa_idx == IDX_W'(g));
        end
        pft_line_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (ev),
            .rd_miss (rd_miss),
            .flag    (flags[g])
        );
        assign hit_vec[g] = flags[g].hit;
        assign iss_vec[g] = flags[g].issued;
        assign dem_vec[g] = flags[g].demand;
        assign unu_vec[g] = flags[g].unused;
    end

    assign inc[CNT_ISSUED] = |iss_vec;
    assign inc[CNT_HIT]    = |hit_vec;
    assign inc[CNT_DEMAND] = |dem_vec;
    assign inc[CNT_UNUSED] = |unu_vec;

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        pft_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[k]),
            .cnt   (cnt_arr[k])
        );
    end

    always_comb begin
        tr_d.vld = |hit_vec;
        tr_d.idx = rd_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tr_q <= '0;
        else        tr_q <= tr_d;
    end

    assign train_vld  = tr_q.vld;
    assign train_idx  = tr_q.idx;
    assign cnt_issued = cnt_arr[CNT_ISSUED];
    assign cnt_hit    = cnt_arr[CNT_HIT];
    assign cnt_demand = cnt_arr[CNT_DEMAND];
    assign cnt_unused = cnt_arr[CNT_UNUSED];

endmodule

// File: rtl/pft_line_tracker_chk.sv
module pft_line_tracker_chk #(
    parameter int IDX_W = 4,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_vld,
    input logic [IDX_W-1:0] rd_idx,
    input logic             ex_vld,
    input logic [IDX_W-1:0] ex_idx,
    input logic             train_vld,
    input logic [IDX_W-1:0] train_idx,
    input logic [CNT_W-1:0] cnt_issued,
    input logic [CNT_W-1:0] cnt_hit,
    input logic [CNT_W-1:0] cnt_demand,
    input logic [CNT_W-1:0] cnt_unused
);

    AST_TRAIN_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        train_vld |-> ($past(rd_vld) && train_idx == $past(rd_idx))); // R4

    AST_TRAIN_BUMPS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_vld) |-> (cnt_hit != $past(cnt_hit) || cnt_hit == {CNT_W{1'b1}})); // R11

    AST_EXCL_BLOCKS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && ex_vld && rd_idx == ex_idx) |=> !train_vld); // R8

    AST_HIT_NOT_ABOVE_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hit <= cnt_demand); // R4

    AST_NO_WRAP_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_issued >= $past(cnt_issued)); // R10

    AST_NO_WRAP_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_unused >= $past(cnt_unused)); // R10

endmodule

bind pft_line_tracker pft_line_tracker_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_vld     (rd_vld),
    .rd_idx     (rd_idx),
    .ex_vld     (ex_vld),
    .ex_idx     (ex_idx),
    .train_vld  (train_vld),
    .train_idx  (train_idx),
    .cnt_issued (cnt_issued),
    .cnt_hit    (cnt_hit),
    .cnt_demand (cnt_demand),
    .cnt_unused (cnt_unused)
);

// File: tb/pft_line_tracker_tb_top.sv
module pft_line_tracker_tb_top;

    localparam int NL    = 4;
    localparam int IW    = 2;
    localparam int CW    = 6;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_vld = 0, rd_miss = 0, ex_vld = 0, rp_vld = 0, pi_vld = 0, pa_vld = 0;
    logic [IW-1:0] rd_idx = 0, ex_idx = 0, rp_idx = 0, pi_idx = 0, pa_idx = 0;
    logic          train_vld;
    logic [IW-1:0] train_idx;
    logic [CW-1:0] cnt_issued, cnt_hit, cnt_demand, cnt_unused;

    always #4 clk = ~clk;

    pft_line_tracker #(.NUM_LINES(NL), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_vld(rd_vld), .rd_idx(rd_idx), .rd_miss(rd_miss),
        .ex_vld(ex_vld), .ex_idx(ex_idx),
        .rp_vld(rp_vld), .rp_idx(rp_idx),
        .pi_vld(pi_vld), .pi_idx(pi_idx),
        .pa_vld(pa_vld), .pa_idx(pa_idx),
        .train_vld(train_vld), .train_idx(train_idx),
        .cnt_issued(cnt_issued), .cnt_hit(cnt_hit),
        .cnt_demand(cnt_demand), .cnt_unused(cnt_unused)
    );

    int n_chk = 0, n_fail = 0;
    int st [NL];
    int e_iss = 0, e_hit = 0, e_dem = 0, e_unu = 0;
    bit e_tv = 0;
    int e_ti = 0;
    string tag = "R1";
    bit done = 0;

    function automatic int sat(input int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("issued", int'(cnt_issued), e_iss);
        chk("hit",    int'(cnt_hit),    e_hit);
        chk("demand", int'(cnt_demand), e_dem);
        chk("unused", int'(cnt_unused), e_unu);
        chk("train_vld", int'(train_vld), int'(e_tv));
        if (e_tv) chk("train_idx", int'(train_idx), e_ti);
    endtask

    // states: 0 idle, 1 waiting, 2 filled
    task automatic tick(input string t,
                        input bit r, input int ri, input bit rm,
                        input bit e, input int ei, input bit p, input int pidx,
                        input bit i, input int ii, input bit a, input int ai);
        @(negedge clk);
        check_all();
        tag = t;
        rd_vld = r; rd_idx = IW'(ri); rd_miss = rm;
        ex_vld = e; ex_idx = IW'(ei);
        rp_vld = p; rp_idx = IW'(pidx);
        pi_vld = i; pi_idx = IW'(ii);
        pa_vld = a; pa_idx = IW'(ai);
        e_tv = 0;
        for (int l = 0; l < NL; l++) begin
            if (e && ei == l) st[l] = 0;
            else if (p && pidx == l) begin
                if (st[l] == 2) e_unu = sat(e_unu);
                st[l] = 0;
            end else if (r && ri == l) begin
                if (st[l] == 2) begin
                    e_hit = sat(e_hit); e_dem = sat(e_dem);
                    e_tv = 1; e_ti = l; st[l] = 0;
                end else if (st[l] == 1 || rm) e_dem = sat(e_dem);
            end else if (a && ai == l) begin
                if (st[l] == 1) st[l] = 2;
            end else if (i && ii == l) begin
                if (st[l] == 0) begin st[l] = 1; e_iss = sat(e_iss); end
            end
        end
    endtask

    task automatic idle(input string t);
        tick(t, 0,0,0, 0,0, 0,0, 0,0, 0,0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        for (int l = 0; l < NL; l++) st[l] = 0;
        repeat (3) @(negedge clk);
        tag = "R1";
        check_all();
        rst_n = 1'b1;
        // R2: issue line 0, then re-issue while waiting
        tick("R2", 0,0,0, 0,0, 0,0, 1,0, 0,0);
        tick("R2", 0,0,0, 0,0, 0,0, 1,0, 0,0);
        // R3: ack on idle line 1 ignored; ack line 0 fills it
        tick("R3", 0,0,0, 0,0, 0,0, 0,0, 1,1);
        tick("R3", 1,1,0, 0,0, 0,0, 0,0, 1,0);
        // R4: read filled line 0 -> hit and train
        tick("R4", 1,0,0, 0,0, 0,0, 0,0, 0,0);
        // R4: second read of line 0 now idle -> no hit
        tick("R4", 1,0,1, 0,0, 0,0, 0,0, 0,0);
        // R5: read to waiting line
        tick("R5", 0,0,0, 0,0, 0,0, 1,2, 0,0);
        tick("R5", 1,2,0, 0,0, 0,0, 0,0, 0,0);
        // R6: fill line 2 then replace it unused
        tick("R6", 0,0,0, 0,0, 0,0, 0,0, 1,2);
        tick("R6", 0,0,0, 0,0, 1,2, 0,0, 0,0);
        // R6: replace a waiting line
        tick("R6", 0,0,0, 0,0, 0,0, 1,3, 0,0);
        tick("R6", 0,0,0, 0,0, 1,3, 0,0, 0,0);
        tick("R6", 1,3,0, 0,0, 0,0, 0,0, 1,3);
        // R7: exclusive to filled line, then read -> no hit
        tick("R7", 0,0,0, 0,0, 0,0, 1,1, 0,0);
        tick("R7", 0,0,0, 0,0, 0,0, 0,0, 1,1);
        tick("R7", 0,0,0, 1,1, 0,0, 0,0, 0,0);
        tick("R7", 1,1,0, 0,0, 0,0, 0,0, 0,0);
        // R8: read and exclusive on one filled line; replace and issue on one idle line
        tick("R8", 0,0,0, 0,0, 0,0, 1,0, 0,0);
        tick("R8", 0,0,0, 0,0, 0,0, 0,0, 1,0);
        tick("R8", 1,0,0, 1,0, 0,0, 0,0, 0,0);
        tick("R8", 0,0,0, 0,0, 1,2, 1,2, 0,0);
        tick("R8", 1,2,0, 0,0, 0,0, 1,2, 1,2);
        // R9: distinct lines in one cycle
        tick("R9", 0,0,0, 0,0, 0,0, 1,0, 0,0);
        tick("R9", 0,0,0, 0,0, 0,0, 1,1, 1,0);
        tick("R9", 1,0,0, 1,3, 0,0, 1,2, 1,1);
        tick("R9", 1,1,0, 0,0, 1,2, 0,0, 0,0);
        // R10: drive issued counter into saturation
        for (int k = 0; k < 80; k++)
            tick("R10", 0,0,0, 1,(k+1)%2, 0,0, 1,k%2, 0,0);
        idle("R10");
        // R11 and all: constrained random mix over few lines
        for (int k = 0; k < 3000; k++) begin
            tick("R11",
                 ($urandom_range(99) < 45), int'($urandom_range(NL-1)), bit'($urandom_range(1)),
                 ($urandom_range(99) < 10), int'($urandom_range(NL-1)),
                 ($urandom_range(99) < 15), int'($urandom_range(NL-1)),
                 ($urandom_range(99) < 50), int'($urandom_range(NL-1)),
                 ($urandom_range(99) < 50), int'($urandom_range(NL-1)));
        end
        idle("R11");
        @(negedge clk);
        check_all();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : seed
        process::self().srandom(32'h5EED_0C1A);
    end

endmodule